// File: doc/BRIEF.md
# Vertical Sync Offset Aligner with Raw Sync Bypass

This block sits at the output of a video sync processor. It takes the processed horizontal sync, vertical sync and field ID, all active high, and places the vertical sync and field ID a programmable number of pixels after or before the horizontal sync. The pixel offset is an 8-bit signed value. To make a negative offset possible, horizontal sync passes through a fixed delay of 128 pixels. Vertical sync and field ID pass through a 256-entry delay line whose tap sits at 128 plus the signed offset. The offset that is in use is reloaded only when a rising edge arrives on the processed vertical sync input. Changing the offset in the middle of a pulse therefore cannot cut that pulse short or send it out twice.

Each output sync can be switched to a bypass. In bypass the raw input sync goes straight to the output, and a per-signal invert bit can flip its polarity. While either bypass is on, the signed offset is ignored and the delayed vertical sync and field ID come out aligned with the delayed horizontal sync. Every output is driven from one shared output register. This project assumes that consecutive vertical sync pulses are more than 256 pixels apart.

Top module: `vsa_sync_align`

## Requirements
- R1: During reset and right after it, hs_o, vs_o and fid_o are 0, and they stay 0 while every sync input is idle low.
- R2: With both bypasses clear, a rising edge on hs_i shows up on hs_o 130 clocks later (128-pixel baseline plus two register stages).
- R3: With both bypasses clear and an offset from 00h to 7Fh, a rising edge on vs_i shows up on vs_o 130 + offset clocks later, which is a delay relative to hs_o.
- R4: With both bypasses clear and an offset from 80h to FFh (two's complement, -128 to -1), vs_o shows up 130 + offset clocks after vs_i, which is an advance relative to hs_o. At 80h the latency is 2 clocks.
- R5: fid_o follows fid_i with exactly the same latency that vs_o has under the offset in use.
- R6: The offset in use is the value on ofs_i at the clock of a vs_i rising edge. A change to ofs_i after that edge does not affect the pulse already in flight. It takes effect at the next vs_i rising edge.
- R7: With hs_bp_i = 1, hs_o equals hs_raw_i XOR hs_inv_i one clock later.
- R8: With vs_bp_i = 1, vs_o equals vs_raw_i XOR vs_inv_i one clock later.
- R9: While its bypass is clear, an invert bit has no effect: idle outputs stay 0, and processed pulses come out with their original polarity.
- R10: While hs_bp_i or vs_bp_i is set, the signed offset is ignored. Every path that is not bypassed among vs_o and fid_o has a 130-clock latency, and hs_o keeps its 130-clock latency when it is not bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_i | input | 1 | Processed horizontal sync, active high |
| vs_i | input | 1 | Processed vertical sync, active high |
| fid_i | input | 1 | Processed field ID |
| hs_raw_i | input | 1 | Raw horizontal sync used in bypass |
| vs_raw_i | input | 1 | Raw vertical sync used in bypass |
| ofs_i | input | 8 | Signed pixel offset of vertical sync against horizontal sync |
| hs_bp_i | input | 1 | Horizontal sync bypass enable |
| vs_bp_i | input | 1 | Vertical sync bypass enable |
| hs_inv_i | input | 1 | Invert the bypassed horizontal sync |
| vs_inv_i | input | 1 | Invert the bypassed vertical sync |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| fid_o | output | 1 | Output field ID |

## Verification
The hardest case to reach from the ports is an offset change while a captured pulse is still in the delay line. That case is what separates a reload on the edge from a tap that follows ofs_i directly. The bench drives a vertical sync pulse under one offset, writes a different offset a few clocks later while the pulse is still travelling, and measures when that pulse comes out. It then sends a second pulse to confirm that the new value has been taken. Each pulse is followed by a quiet window longer than the delay line, so every latency is measured from an empty line.

// File: rtl/vsa_pkg.sv
package vsa_pkg;

    typedef struct packed {
        logic hs;
        logic vs;
        logic fid;
    } vsa_sync_t;

endpackage

// File: rtl/vsa_delay_line.sv
module vsa_delay_line #(
    parameter  int WIDTH = 2,
    parameter  int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [IDX_W-1:0] tap_idx,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] line_d [DEPTH];
    logic [WIDTH-1:0] line_q [DEPTH];

    always_comb begin
        line_d[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            line_d[i] = line_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            line_q <= line_d;
        end
    end

    assign dout = line_q[tap_idx];

endmodule

// File: rtl/vsa_ofs_ctrl.sv
module vsa_ofs_ctrl #(
    parameter int               OFS_W   = 8,
    parameter logic [OFS_W-1:0] RST_OFS = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             byp_any_i,
    output logic [OFS_W-1:0] tap_o
);

    localparam logic [OFS_W-1:0] BIAS = {1'b1, {(OFS_W-1){1'b0}}};

    typedef struct packed {
        logic             vs_prev;
        logic [OFS_W-1:0] ofs;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic vs_rise;

    always_comb begin
        vs_rise       = vs_i & ~ctl_q.vs_prev;
        ctl_d.vs_prev = vs_i;
        ctl_d.ofs     = vs_rise ? ofs_i : ctl_q.ofs;
        // Adding BIAS to a signed value equals flipping its sign bit.
        if (byp_any_i) begin
            tap_o = BIAS;
        end else begin
            tap_o = {~ctl_q.ofs[OFS_W-1], ctl_q.ofs[OFS_W-2:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.vs_prev <= 1'b0;
            ctl_q.ofs     <= RST_OFS;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_OFS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_i && !ctl_q.vs_prev) |=> (ctl_q.ofs == $past(ofs_i))); // R6

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs_i && !ctl_q.vs_prev) |=> $stable(ctl_q.ofs)); // R6

endmodule

// File: rtl/vsa_sync_align.sv
module vsa_sync_align
    import vsa_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_i,
    input  logic             vs_i,
    input  logic             fid_i,
    input  logic             hs_raw_i,
    input  logic             vs_raw_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             hs_bp_i,
    input  logic             vs_bp_i,
    input  logic             hs_inv_i,
    input  logic             vs_inv_i,
    output logic             hs_o,
    output logic             vs_o,
    output logic             fid_o
);

    localparam int               VAR_DEPTH = 2 ** OFS_W;
    localparam int               BASE      = VAR_DEPTH / 2;
    localparam int               HS_DEPTH  = BASE + 1;
    localparam int               HS_IDX_W  = $clog2(HS_DEPTH);
    localparam logic [HS_IDX_W-1:0] HS_TAP = HS_IDX_W'(BASE);

    logic [OFS_W-1:0] var_tap;
    logic             hs_dly;
    logic [1:0]       vf_dly;
    vsa_sync_t        out_d, out_q;

    vsa_ofs_ctrl #(
        .OFS_W   (OFS_W),
        .RST_OFS (OFS_W'(16))
    ) i_ofs_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vs_i      (vs_i),
        .ofs_i     (ofs_i),
        .byp_any_i (hs_bp_i | vs_bp_i),
        .tap_o     (var_tap)
    );

    vsa_delay_line #(
        .WIDTH (1),
        .DEPTH (HS_DEPTH)
    ) i_hs_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (hs_i),
        .tap_idx (HS_TAP),
        .dout    (hs_dly)
    );

    vsa_delay_line #(
        .WIDTH (2),
        .DEPTH (VAR_DEPTH)
    ) i_vf_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     ({vs_i, fid_i}),
        .tap_idx (var_tap),
        .dout    (vf_dly)
    );

    always_comb begin
        out_d.hs  = hs_bp_i ? (hs_raw_i ^ hs_inv_i) : hs_dly;
        out_d.vs  = vs_bp_i ? (vs_raw_i ^ vs_inv_i) : vf_dly[1];
        out_d.fid = vf_dly[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hs_o  = out_q.hs;
    assign vs_o  = out_q.vs;
    assign fid_o = out_q.fid;

    AST_HS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hs_bp_i)) |->
            (hs_o == ($past(hs_raw_i) != $past(hs_inv_i)))); // R7

    AST_VS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vs_bp_i)) |->
            (vs_o == ($past(vs_raw_i) != $past(vs_inv_i)))); // R8

endmodule

// File: tb/test_vsa_sync_align.sv
module test_vsa_sync_align;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_i = 1'b0, vs_i = 1'b0, fid_i = 1'b0;
    logic       hs_raw_i = 1'b0, vs_raw_i = 1'b0;
    logic [7:0] ofs_i = 8'h10;
    logic       hs_bp_i = 1'b0, vs_bp_i = 1'b0;
    logic       hs_inv_i = 1'b0, vs_inv_i = 1'b0;
    logic       hs_o, vs_o, fid_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vsa_sync_align i_vsa_sync_align (
        .clk(clk), .rst_n(rst_n), .hs_i(hs_i), .vs_i(vs_i), .fid_i(fid_i),
        .hs_raw_i(hs_raw_i), .vs_raw_i(vs_raw_i), .ofs_i(ofs_i),
        .hs_bp_i(hs_bp_i), .vs_bp_i(vs_bp_i), .hs_inv_i(hs_inv_i),
        .vs_inv_i(vs_inv_i), .hs_o(hs_o), .vs_o(vs_o), .fid_o(fid_o)
    );

    localparam int NVEC = 7;
    localparam logic [7:0] OFS_VEC [NVEC] =
        '{8'h00, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'hC0, 8'h25};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse all processed syncs for w clocks; report first-high latency
    // in clocks for each output (-1 if never seen within the window).
    task automatic pulse_measure(input int w, input int chg_at,
                                 input logic [7:0] chg_val,
                                 output int lh, output int lv, output int lf);
        lh = -1; lv = -1; lf = -1;
        @(negedge clk);
        hs_i = 1'b1; vs_i = 1'b1; fid_i = 1'b1;
        for (int c = 1; c <= 400; c++) begin
            @(negedge clk);
            if (c == w) begin
                hs_i = 1'b0; vs_i = 1'b0; fid_i = 1'b0;
            end
            if (c == chg_at) ofs_i = chg_val;
            if (hs_o && lh < 0) lh = c;
            if (vs_o && lv < 0) lv = c;
            if (fid_o && lf < 0) lf = c;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int lh, lv, lf;
        repeat (3) @(negedge clk);
        chk("R1 reset hs_o", int'(hs_o), 0);
        chk("R1 reset vs_o", int'(vs_o), 0);
        chk("R1 reset fid_o", int'(fid_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle outputs", int'({hs_o, vs_o, fid_o}), 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            ofs_i = OFS_VEC[v];
            pulse_measure(4, 0, 8'h00, lh, lv, lf);
            chk("R2 hs latency", lh, 130);
            chk((OFS_VEC[v][7] ? "R4 vs latency" : "R3 vs latency"),
                lv, 130 + int'($signed(OFS_VEC[v])));
            chk("R5 fid latency", lf, 130 + int'($signed(OFS_VEC[v])));
        end

        // R6: offset change mid-flight does not touch the captured pulse
        ofs_i = 8'h20;
        pulse_measure(4, 6, 8'hF0, lh, lv, lf);
        chk("R6 in-flight pulse keeps old offset", lv, 130 + 32);
        chk("R6 fid keeps old offset", lf, 130 + 32);
        pulse_measure(4, 0, 8'h00, lh, lv, lf);
        chk("R6 next pulse uses new offset", lv, 130 - 16);

        // R9: invert bits inert without bypass
        hs_inv_i = 1'b1; vs_inv_i = 1'b1; ofs_i = 8'h05;
        repeat (3) @(negedge clk);
        chk("R9 idle hs_o with invert", int'(hs_o), 0);
        chk("R9 idle vs_o with invert", int'(vs_o), 0);
        pulse_measure(4, 0, 8'h00, lh, lv, lf);
        chk("R9 hs polarity kept", lh, 130);
        chk("R9 vs polarity kept", lv, 135);
        hs_inv_i = 1'b0; vs_inv_i = 1'b0;

        // R7: HSYNC bypass
        hs_bp_i = 1'b1; hs_raw_i = 1'b1;
        @(negedge clk);
        chk("R7 hs raw high", int'(hs_o), 1);
        hs_inv_i = 1'b1;
        @(negedge clk);
        chk("R7 hs raw high inverted", int'(hs_o), 0);
        hs_raw_i = 1'b0;
        @(negedge clk);
        chk("R7 hs raw low inverted", int'(hs_o), 1);
        chk("R7 vs unaffected", int'(vs_o), 0);
        hs_inv_i = 1'b0;
        @(negedge clk);
        chk("R7 hs raw low", int'(hs_o), 0);

        // R10: offset ignored with hs bypass
        ofs_i = 8'h28;
        pulse_measure(4, 0, 8'h00, lh, lv, lf);
        chk("R10 hs bypassed stays low", lh, -1);
        chk("R10 vs zero offset under hs bypass", lv, 130);
        chk("R10 fid zero offset under hs bypass", lf, 130);
        hs_bp_i = 1'b0;

        // R8: VSYNC bypass
        vs_bp_i = 1'b1; vs_raw_i = 1'b1;
        @(negedge clk);
        chk("R8 vs raw high", int'(vs_o), 1);
        vs_inv_i = 1'b1;
        @(negedge clk);
        chk("R8 vs raw high inverted", int'(vs_o), 0);
        vs_raw_i = 1'b0;
        @(negedge clk);
        chk("R8 vs raw low inverted", int'(vs_o), 1);
        chk("R8 hs unaffected", int'(hs_o), 0);
        vs_inv_i = 1'b0;
        @(negedge clk);
        chk("R8 vs raw low", int'(vs_o), 0);

        // R10: offset ignored with vs bypass
        ofs_i = 8'hCE;
        pulse_measure(4, 0, 8'h00, lh, lv, lf);
        chk("R10 hs latency under vs bypass", lh, 130);
        chk("R10 vs bypassed stays low", lv, -1);
        chk("R10 fid zero offset under vs bypass", lf, 130);
        vs_bp_i = 1'b0;

        // Back to normal: the offset captured at the last edge applies
        pulse_measure(4, 0, 8'h00, lh, lv, lf);
        chk("R4 offset resumes after bypass", lv, 130 - 50);

        // R1: reset mid-stream clears outputs
        ofs_i = 8'h00;
        @(negedge clk);
        hs_i = 1'b1; vs_i = 1'b1; fid_i = 1'b1;
        repeat (4) @(negedge clk);
        hs_i = 1'b0; vs_i = 1'b0; fid_i = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk("R1 line flushed by reset", int'({hs_o, vs_o, fid_o}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule